// File: doc/BRIEF.md
# Serial Memory Write-Enable Latch Controller

This block is the instruction front end of a serial memory that sits on an SPI bus as a slave. While chip select is held low it collects instruction bits from the serial data line, one on each rising edge of the serial clock, most significant bit first. Nothing is acted on while the bus is still selected. The collected byte is executed only when chip select returns high, and only if exactly eight clock edges arrived during the low period.

Two opcodes matter here. 0x06 sets the write-enable latch and 0x04 clears it. The latch drives a permission output that the write engine and the status-register-write engine consult before they start, and both engines refuse to run while it is low. A completion strobe from either engine clears the latch, so every write needs its own fresh enable. An enable request that arrives while an operation is still busy is dropped.

The serial pins are brought into the core clock domain through synchronizer chains whose depth is a parameter. The serial output driver is never enabled, because none of these sequences returns data.

Top module: `spi_wel_top`

## Requirements
- R1: While reset is asserted and directly after it, `wr_enable` is 0 and `spi_miso_oe` is 0.
- R2: The byte 0x06, shifted in MSB first on eight rising `spi_sclk` edges while `spi_cs_n` is low, sets `wr_enable` to 1 once `spi_cs_n` rises.
- R3: The byte 0x04, received the same way, clears `wr_enable` to 0 once `spi_cs_n` rises.
- R4: Any other 8-bit byte leaves `wr_enable` unchanged.
- R5: If `spi_cs_n` rises after a number of rising clock edges other than eight (for example 7, 9 or 16), the instruction is dropped and `wr_enable` is unchanged.
- R6: A complete instruction has no effect while `spi_cs_n` stays low. It takes effect only after `spi_cs_n` rises.
- R7: A rise of `spi_cs_n` restarts bit counting, so after an aborted partial instruction the next low period decodes a fresh byte.
- R8: A high level on `wr_done` or on `wrsr_done` clears `wr_enable`. The clear takes priority over a set executing in the same cycle.
- R9: 0x06 has no effect while `op_busy` is 1.
- R10: `spi_miso_oe` is never 1, so the serial output stays high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out value |
| spi_miso_oe | output | 1 | Output driver enable (0 = high impedance) |
| op_busy | input | 1 | A write or status-register write is in progress |
| wr_done | input | 1 | Data write completion strobe |
| wrsr_done | input | 1 | Status-register write completion strobe |
| wr_enable | output | 1 | Write-enable latch, grants write permission |

## Verification
All 256 byte values are sent as complete 8-bit instructions twice: once with the latch already set and once with it already clear. The set-state pass separates the clearing opcode from every opcode that should do nothing. The clear-state pass separates the enabling opcode from the rest. Frames of 7, 9 and 16 bits, and an enable held back with chip select still low, separate the deselect rule and the exact-count rule from plain opcode matching. An aborted frame followed by a complete one shows that the counter restarts. Enables sent while busy, or overlapping a held completion strobe, show that blocking and clear priority behave as required.

// File: rtl/spi_wel_pkg.sv
package spi_wel_pkg;
   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_SET  = 2'd1,
      CMD_CLR  = 2'd2
   } wel_cmd_e;
endpackage

// File: rtl/spi_wel_sync.sv
module spi_wel_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RST_VAL;
               else        chain_q[s] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= RST_VAL;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi_wel_shifter.sv
module spi_wel_shifter #(
   parameter int INSTR_W   = 8,
   parameter int CNT_W     = 4,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_active,
   input  logic               sclk_rise,
   input  logic               mosi,
   output logic [INSTR_W-1:0] instr,
   output logic [CNT_W-1:0]   bit_cnt,
   output logic               frame_ok
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(INSTR_W);
   localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(INSTR_W + 1);

   logic [INSTR_W-1:0] shreg_q;
   logic [INSTR_W-1:0] shreg_d;

   generate
      if (MSB_FIRST) begin : g_msb
         assign shreg_d = {shreg_q[INSTR_W-2:0], mosi};
      end else begin : g_lsb
         assign shreg_d = {mosi, shreg_q[INSTR_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg_q <= '0;
      end else if (!cs_active) begin
         bit_cnt <= '0;
      end else if (sclk_rise) begin
         shreg_q <= shreg_d;
         if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
      end
   end

   assign instr    = shreg_q;
   assign frame_ok = (bit_cnt == CNT_FULL);
endmodule

// File: rtl/spi_wel_latch.sv
module spi_wel_latch
   import spi_wel_pkg::*;
#(
   parameter int                 INSTR_W = 8,
   parameter logic [INSTR_W-1:0] OPC_SET = 8'h06,
   parameter logic [INSTR_W-1:0] OPC_CLR = 8'h04
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exec,
   input  logic [INSTR_W-1:0] instr,
   input  logic               op_busy,
   input  logic               wr_done,
   input  logic               wrsr_done,
   output wel_cmd_e           cmd,
   output logic               wel
);
   always_comb begin
      cmd = CMD_NONE;
      if (exec) begin
         if (instr == OPC_SET)      cmd = CMD_SET;
         else if (instr == OPC_CLR) cmd = CMD_CLR;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      wel <= 1'b0;
      else if (wr_done || wrsr_done || cmd == CMD_CLR) wel <= 1'b0;
      else if (cmd == CMD_SET && !op_busy)             wel <= 1'b1;
   end
endmodule

// File: rtl/spi_wel_top.sv
module spi_wel_top
   import spi_wel_pkg::*;
#(
   parameter int                 SYNC_STAGES = 2,
   parameter int                 INSTR_W     = 8,
   parameter bit                 MSB_FIRST   = 1'b1,
   parameter logic [INSTR_W-1:0] OPC_SET     = 8'h06,
   parameter logic [INSTR_W-1:0] OPC_CLR     = 8'h04
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sclk,
   input  logic spi_cs_n,
   input  logic spi_mosi,
   output logic spi_miso,
   output logic spi_miso_oe,
   input  logic op_busy,
   input  logic wr_done,
   input  logic wrsr_done,
   output logic wr_enable
);
   localparam int CNT_W = $clog2(INSTR_W + 2);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (INSTR_W < 2) begin : g_bad_width
         $error("INSTR_W must be at least 2");
      end
      if (OPC_SET == OPC_CLR) begin : g_bad_opc
         $error("OPC_SET and OPC_CLR must differ");
      end
   endgenerate

   logic sclk_s, cs_s, mosi_s;
   logic sclk_prev_q, cs_prev_q;
   logic sclk_rise, cs_rise, cs_active;
   logic [INSTR_W-1:0] instr;
   logic [CNT_W-1:0]   bit_cnt;
   logic               frame_ok;
   wel_cmd_e           cmd;

   spi_wel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .din(spi_sclk), .dout(sclk_s));
   spi_wel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .din(spi_cs_n), .dout(cs_s));
   spi_wel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .din(spi_mosi), .dout(mosi_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev_q <= 1'b0;
         cs_prev_q   <= 1'b1;
      end else begin
         sclk_prev_q <= sclk_s;
         cs_prev_q   <= cs_s;
      end
   end

   assign sclk_rise = sclk_s & ~sclk_prev_q;
   assign cs_rise   = cs_s & ~cs_prev_q;
   assign cs_active = ~cs_s;

   spi_wel_shifter #(.INSTR_W(INSTR_W), .CNT_W(CNT_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .sclk_rise(sclk_rise),
      .mosi(mosi_s), .instr(instr), .bit_cnt(bit_cnt), .frame_ok(frame_ok));

   spi_wel_latch #(.INSTR_W(INSTR_W), .OPC_SET(OPC_SET), .OPC_CLR(OPC_CLR)) u_latch (
      .clk(clk), .rst_n(rst_n), .exec(cs_rise & frame_ok), .instr(instr),
      .op_busy(op_busy), .wr_done(wr_done), .wrsr_done(wrsr_done),
      .cmd(cmd), .wel(wr_enable));

   assign spi_miso    = 1'b0;
   assign spi_miso_oe = 1'b0;
endmodule

// File: rtl/spi_wel_chk.sv
module spi_wel_chk
   import spi_wel_pkg::*;
#(
   parameter int INSTR_W = 8,
   parameter int CNT_W   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_s,
   input logic             cs_rise,
   input logic [CNT_W-1:0] bit_cnt,
   input wel_cmd_e         cmd,
   input logic             wel,
   input logic             op_busy,
   input logic             wr_done,
   input logic             wrsr_done
);
   a_r2_set_via_wren: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> ($past(cmd) == CMD_SET) && !$past(op_busy));

   a_r3_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_CLR) |=> !wel);

   a_r5_bad_count_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && bit_cnt != CNT_W'(INSTR_W) && !wr_done && !wrsr_done) |=> $stable(wel));

   a_r7_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> (bit_cnt == '0));

   a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done || wrsr_done) |=> !wel);

   a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (op_busy && !wel) |=> !wel);
endmodule

bind spi_wel_top spi_wel_chk #(.INSTR_W(INSTR_W), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_rise(cs_rise), .bit_cnt(bit_cnt),
   .cmd(cmd), .wel(wr_enable), .op_busy(op_busy), .wr_done(wr_done),
   .wrsr_done(wrsr_done));

// File: tb/spi_wel_top_tb_top.sv
module spi_wel_top_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic op_busy = 1'b0, wr_done = 1'b0, wrsr_done = 1'b0;
   logic spi_miso, spi_miso_oe, wr_enable;

   int checks = 0;
   int fails = 0;
   int oe_seen = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   spi_wel_top dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
      .op_busy(op_busy), .wr_done(wr_done), .wrsr_done(wrsr_done),
      .wr_enable(wr_enable));

   always @(negedge clk) if (spi_miso_oe !== 1'b0) oe_seen++;

   task automatic check(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic shift_bits(input logic [15:0] v, input int n);
      spi_cs_n = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = n - 1; i >= 0; i--) begin
         spi_mosi = v[i];
         repeat (3) @(negedge clk);
         spi_sclk = 1'b1;
         repeat (3) @(negedge clk);
         spi_sclk = 1'b0;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic release_cs();
      spi_cs_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic send(input logic [15:0] v, input int n);
      shift_bits(v, n);
      release_cs();
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check("R1 reset latch", wr_enable, 1'b0);
      check("R1 reset oe", spi_miso_oe, 1'b0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 after reset", wr_enable, 1'b0);

      // R2/R3/R4 sweep: every opcode from the set state and the clear state
      for (int op = 0; op < 256; op++) begin
         send(16'h0006, 8);
         send(16'(op), 8);
         if (op == 8'h04) check("R3 clear from set", wr_enable, 1'b0);
         else             check("R4 other opcode from set", wr_enable, 1'b1);
         send(16'h0004, 8);
         send(16'(op), 8);
         if (op == 8'h06) check("R2 set from clear", wr_enable, 1'b1);
         else             check("R4 other opcode from clear", wr_enable, 1'b0);
      end

      // R5: wrong bit counts
      send(16'h0004, 8);
      send(16'h0003, 7);  // first 7 bits of 0x06
      check("R5 seven bits", wr_enable, 1'b0);
      send(16'h000C, 9);  // 0x06 followed by one extra bit
      check("R5 nine bits", wr_enable, 1'b0);
      send(16'h0606, 16);
      check("R5 sixteen bits", wr_enable, 1'b0);
      send(16'h0006, 8);
      send(16'h0002, 7);  // first 7 bits of 0x04
      check("R5 short clear dropped", wr_enable, 1'b1);

      // R6: no action until deselect
      send(16'h0004, 8);
      shift_bits(16'h0006, 8);
      repeat (12) @(negedge clk);
      check("R6 held while selected", wr_enable, 1'b0);
      release_cs();
      check("R6 acts on deselect", wr_enable, 1'b1);

      // R7: aborted frame then fresh instruction
      send(16'h0004, 8);
      send(16'h0005, 5);
      send(16'h0006, 8);
      check("R7 fresh frame after abort", wr_enable, 1'b1);

      // R8: completion strobes clear
      wr_done = 1'b1; @(negedge clk); wr_done = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 write done clears", wr_enable, 1'b0);
      send(16'h0006, 8);
      wrsr_done = 1'b1; @(negedge clk); wrsr_done = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 status write done clears", wr_enable, 1'b0);
      shift_bits(16'h0006, 8);
      wr_done = 1'b1;
      release_cs();
      wr_done = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 clear beats set", wr_enable, 1'b0);

      // R9: enable blocked while busy
      op_busy = 1'b1;
      send(16'h0006, 8);
      check("R9 busy blocks set", wr_enable, 1'b0);
      op_busy = 1'b0;
      send(16'h0006, 8);
      check("R9 set after busy", wr_enable, 1'b1);

      check("R10 output never driven", (oe_seen == 0), 1'b1);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule